// File: doc/BRIEF.md
# Cycle-Stealing Single-Channel DMA Controller

This block moves a block of words between one peripheral and main memory on a system bus that it shares with the CPU. The CPU fills in a device address, a starting memory address and a word count. It then writes a command word that gives the direction and starts the transfer. From that point the controller works alone. It requests the bus, waits for the grant and takes the bus for a single word. It then hands the bus back, so the CPU is only held off at its next bus access and never loses its context.

The controller is detached from both endpoints, so every word takes two granted bus cycles. The first cycle is a read from the source into an internal holding register. The second cycle is a write of that register to the destination. Device cycles and memory cycles are told apart by a space-select line, as on an isolated I/O bus. After each word the memory address steps up by one and the remaining count steps down by one. When the count reaches zero the controller sets a done flag and raises an interrupt. A status read or an acknowledge command clears both.

Top module: `dma_steal`

## Requirements
- R1: Register offsets on `cfg_addr`: 0 is the device address, 1 is the memory address, 2 is the word count, and 3 is the command on write and the status on read. Offsets 0 to 2 read back their current values. Writes to offsets 0 to 2 are ignored while busy.
- R2: The command word has three bits: bit0 starts a transfer, bit1 gives the direction (0 = device to memory, 1 = memory to device) and bit2 acknowledges. An accepted start with a nonzero count raises `bus_req` in the next cycle. `bus_rd` and `bus_wr` stay low until a cycle in which `bus_gnt` was sampled high while requesting.
- R3: Each word uses two consecutive granted cycles, a read cycle and then a write cycle. For device-to-memory transfers, the read cycle has `bus_io`=1 with the device address and the write cycle has `bus_io`=0 with the memory address. Memory-to-device transfers swap the two.
- R4: The write cycle of a word drives on `bus_wdata` the value that was on `bus_rdata` in that word's read cycle.
- R5: `bus_req` is low in the cycle after every write cycle. It rises again in the following cycle if words remain.
- R6: After each word the memory address increases by 1 and the count decreases by 1. Both values can be read back.
- R7: After the last word, busy falls and done and `irq` rise in the cycle after the write cycle. The count then reads 0.
- R8: Done and `irq` are cleared by a status read or by a command write with bit2 set. An accepted nonzero start also clears done. A done being set in the same cycle wins over a clear.
- R9: A start with a count of 0 sets done and `irq` in the next cycle and performs no bus cycle.
- R10: A start command written while busy is ignored: the direction, count and addresses in use are unchanged.
- R11: After reset, `bus_req`, `bus_rd`, `bus_wr` and `irq` are low and the status reads 0. The status bits are bit0 busy and bit1 done.
- R12: `bus_rd` and `bus_wr` are never high together, and neither is high without `bus_gnt`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | CPU register write strobe |
| cfg_re | input | 1 | CPU register read strobe (status read clears done) |
| cfg_addr | input | 2 | Register offset |
| cfg_wdata | input | AW | Register write data |
| cfg_rdata | output | AW | Register read data (combinational) |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant, held while requested |
| bus_rd | output | 1 | Read strobe of a stolen cycle |
| bus_wr | output | 1 | Write strobe of a stolen cycle |
| bus_io | output | 1 | 1 selects device space, 0 memory space |
| bus_addr | output | AW | Bus address, 0 when idle |
| bus_wdata | output | DW | Write data, 0 outside write cycles |
| bus_rdata | input | DW | Read data returned in the read cycle |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions check several rules on every cycle. The two strobes are never active together, and no strobe appears without a grant. A read cycle is always followed by a write cycle, and that write carries the data just read. The request drops after every write. They also follow the count step, completion, zero-count start and ignored-start rules at the moment each event occurs. Only the bench scenarios can show that whole blocks land at the right addresses in the right direction, that grant latency just stretches the request phase, and that register writes issued in mid-transfer leave the block unchanged.

// File: rtl/dma_steal_pkg.sv
package dma_steal_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_REQ,
    PH_RD,
    PH_WR,
    PH_REL
  } phase_e;

  localparam logic [1:0] RA_DEV = 2'd0;
  localparam logic [1:0] RA_MEM = 2'd1;
  localparam logic [1:0] RA_CNT = 2'd2;
  localparam logic [1:0] RA_CMD = 2'd3;

  localparam int CMD_GO  = 0;
  localparam int CMD_DIR = 1;
  localparam int CMD_ACK = 2;
endpackage

// File: rtl/dma_steal_regs.sv
module dma_steal_regs
  import dma_steal_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_re,
  input  logic [1:0]    cfg_addr,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] cfg_rdata,
  input  logic          busy,
  input  logic          word_done,
  output logic [AW-1:0] dev_addr,
  output logic [AW-1:0] mem_addr,
  output logic          dir,
  output logic          last_word,
  output logic          go,
  output logic          done
);
  function automatic logic [AW-1:0] step_up(input logic [AW-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic logic [AW-1:0] step_down(input logic [AW-1:0] c);
    return c - 1'b1;
  endfunction

  logic [AW-1:0] words_left;
  logic wr_cmd, start_try, start_acc, zero_start, blk_done, set_done, clr_done;

  assign wr_cmd     = cfg_we && (cfg_addr == RA_CMD);
  assign start_try  = wr_cmd && cfg_wdata[CMD_GO];
  assign start_acc  = start_try && !busy;
  assign zero_start = start_acc && (words_left == '0);
  assign go         = start_acc && (words_left != '0);
  assign last_word  = (words_left == AW'(1));
  assign blk_done   = word_done && last_word;
  assign set_done   = blk_done || zero_start;
  assign clr_done   = (wr_cmd && cfg_wdata[CMD_ACK]) ||
                      (cfg_re && (cfg_addr == RA_CMD)) || go;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dev_addr   <= '0;
      mem_addr   <= '0;
      words_left <= '0;
      dir        <= 1'b0;
      done       <= 1'b0;
    end else begin
      if (set_done)      done <= 1'b1;
      else if (clr_done) done <= 1'b0;
      if (start_acc) dir <= cfg_wdata[CMD_DIR];
      if (cfg_we && !busy && cfg_addr == RA_DEV) dev_addr <= cfg_wdata;
      if (word_done) begin
        mem_addr   <= step_up(mem_addr);
        words_left <= step_down(words_left);
      end else if (cfg_we && !busy) begin
        if (cfg_addr == RA_MEM) mem_addr   <= cfg_wdata;
        if (cfg_addr == RA_CNT) words_left <= cfg_wdata;
      end
    end
  end

  always_comb begin
    case (cfg_addr)
      RA_DEV:  cfg_rdata = dev_addr;
      RA_MEM:  cfg_rdata = mem_addr;
      RA_CNT:  cfg_rdata = words_left;
      default: cfg_rdata = {{(AW-2){1'b0}}, done, busy};
    endcase
  end

  a_r6_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> (words_left == AW'($past(words_left) - 1'b1)) &&
                  (mem_addr == AW'($past(mem_addr) + 1'b1)));
  a_r7_last_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> done && (words_left == '0));
  a_r8_clear_done: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_done && !set_done) |=> !done);
  a_r9_zero_start: assert property (@(posedge clk) disable iff (!rst_n)
    zero_start |=> done && !go);
  a_r10_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start_try && busy && !word_done) |=> $stable(words_left) && $stable(dir) &&
                                          $stable(dev_addr) && $stable(mem_addr));
endmodule

// File: rtl/dma_steal_fsm.sv
module dma_steal_fsm
  import dma_steal_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          dir,
  input  logic          last_word,
  input  logic [AW-1:0] dev_addr,
  input  logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] hold_q,
  input  logic          bus_gnt,
  output logic          busy,
  output logic          word_done,
  output logic          cap_en,
  output logic          bus_req,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic          bus_io,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata
);
  phase_e ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    case (ph_q)
      PH_IDLE: if (go) ph_d = PH_REQ;
      PH_REQ:  if (bus_gnt) ph_d = PH_RD;
      PH_RD:   ph_d = PH_WR;
      PH_WR:   ph_d = last_word ? PH_IDLE : PH_REL;
      PH_REL:  ph_d = PH_REQ;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  assign busy      = (ph_q != PH_IDLE);
  assign bus_req   = (ph_q == PH_REQ) || (ph_q == PH_RD) || (ph_q == PH_WR);
  assign bus_rd    = (ph_q == PH_RD);
  assign bus_wr    = (ph_q == PH_WR);
  assign cap_en    = bus_rd;
  assign word_done = bus_wr;
  assign bus_wdata = bus_wr ? hold_q : '0;

  always_comb begin
    bus_io   = 1'b0;
    bus_addr = '0;
    if (bus_rd) begin
      bus_io   = !dir;
      bus_addr = dir ? mem_addr : dev_addr;
    end else if (bus_wr) begin
      bus_io   = dir;
      bus_addr = dir ? dev_addr : mem_addr;
    end
  end

  a_r2_req_after_go: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> bus_req && !bus_rd && !bus_wr);
  a_r3_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_wr && (bus_io != $past(bus_io)));
  a_r5_release_after_word: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |=> !bus_req);
  a_r12_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));
  a_r12_strobe_needs_gnt: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |-> bus_gnt);
endmodule

// File: rtl/dma_steal_hold.sv
module dma_steal_hold #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] hold_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      hold_q <= '0;
    else if (cap_en) hold_q <= din;
  end
endmodule

// File: rtl/dma_steal.sv
module dma_steal #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_re,
  input  logic [1:0]    cfg_addr,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] cfg_rdata,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic          bus_io,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  output logic          irq
);
  logic          busy, word_done, cap_en, go, dir, last_word, done;
  logic [AW-1:0] dev_addr, mem_addr;
  logic [DW-1:0] hold_q;

  dma_steal_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .busy(busy), .word_done(word_done),
    .dev_addr(dev_addr), .mem_addr(mem_addr), .dir(dir),
    .last_word(last_word), .go(go), .done(done)
  );

  dma_steal_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .go(go), .dir(dir), .last_word(last_word),
    .dev_addr(dev_addr), .mem_addr(mem_addr), .hold_q(hold_q),
    .bus_gnt(bus_gnt), .busy(busy), .word_done(word_done), .cap_en(cap_en),
    .bus_req(bus_req), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_io(bus_io),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata)
  );

  dma_steal_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en),
    .din(bus_rdata), .hold_q(hold_q)
  );

  assign irq = done;

  a_r4_data_carried: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> (bus_wdata == $past(bus_rdata)));
  a_r7_irq_when_idle_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !busy);
endmodule

// File: tb/dma_steal_bench.sv
module dma_steal_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_re = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic [AW-1:0] cfg_rdata;
  logic bus_req, bus_rd, bus_wr, bus_io, irq;
  logic bus_gnt = 1'b0;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;

  int checks = 0, errors = 0, cycles = 0;
  int gnt_delay = 0, gnt_wait = 0;
  int dev_seq = 0;
  logic [DW-1:0] mem [0:255];
  logic [DW-1:0] dev_log [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_steal #(.AW(AW), .DW(DW)) u_dma_steal (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_re(cfg_re),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_io(bus_io), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  // Behavioural memory and device on the bus
  assign bus_rdata = !bus_rd ? '0 :
                     (bus_io ? DW'(32'hC000 + dev_seq) : mem[bus_addr[7:0]]);

  always @(posedge clk) begin
    if (bus_rd && bus_io) dev_seq = dev_seq + 1;
    if (bus_wr && !bus_io) mem[bus_addr[7:0]] = bus_wdata;
    if (bus_wr && bus_io) dev_log.push_back(bus_wdata);
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Cycle-by-cycle reference model
  int ph = 0;
  logic [15:0] m_dev = '0, m_mem = '0, m_cnt = '0;
  logic m_dir = 1'b0, m_done = 1'b0;
  bit set_d, clr_d, ob;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; m_dev = '0; m_mem = '0; m_cnt = '0; m_dir = 1'b0; m_done = 1'b0;
    end else begin
      set_d = 1'b0; clr_d = 1'b0; ob = (ph != 0);
      case (ph)
        1: if (bus_gnt) ph = 2;
        2: ph = 3;
        3: begin
          m_mem = m_mem + 1'b1; m_cnt = m_cnt - 1'b1;
          if (m_cnt == 0) begin set_d = 1'b1; ph = 0; end else ph = 4;
        end
        4: ph = 1;
        default: ;
      endcase
      if (cfg_re && cfg_addr == 2'd3) clr_d = 1'b1;
      if (cfg_we) begin
        case (cfg_addr)
          2'd0: if (!ob) m_dev = cfg_wdata;
          2'd1: if (!ob) m_mem = cfg_wdata;
          2'd2: if (!ob) m_cnt = cfg_wdata;
          default: begin
            if (cfg_wdata[2]) clr_d = 1'b1;
            if (cfg_wdata[0] && !ob) begin
              m_dir = cfg_wdata[1];
              if (m_cnt == 0) set_d = 1'b1;
              else begin ph = 1; clr_d = 1'b1; end
            end
          end
        endcase
      end
      if (set_d) m_done = 1'b1;
      else if (clr_d) m_done = 1'b0;
    end
  end

  always @(negedge clk) begin
    logic e_req, e_rd, e_wr, e_io;
    logic [15:0] e_addr;
    cycles++;
    if (rst_n) begin
      e_req = (ph == 1) || (ph == 2) || (ph == 3);
      e_rd = (ph == 2);
      e_wr = (ph == 3);
      e_io = 1'b0; e_addr = '0;
      if (e_rd) begin e_io = !m_dir; e_addr = m_dir ? m_mem : m_dev; end
      if (e_wr) begin e_io = m_dir;  e_addr = m_dir ? m_dev : m_mem; end
      chk(bus_req == e_req, "R2 R5 bus_req", bus_req, e_req);
      chk(bus_rd == e_rd && bus_wr == e_wr, "R3 R12 strobes",
          {bus_rd, bus_wr}, {e_rd, e_wr});
      chk(bus_io == e_io && bus_addr == e_addr, "R3 R6 space/address",
          {bus_io, bus_addr}, {e_io, e_addr});
      chk(irq == m_done, "R7 R8 R9 irq", irq, m_done);
      if (bus_req && gnt_wait >= gnt_delay) bus_gnt = 1'b1;
      else if (bus_req) begin bus_gnt = 1'b0; gnt_wait++; end
      else begin bus_gnt = 1'b0; gnt_wait = 0; end
    end
  end

  task automatic cfg_write(input logic [1:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [1:0] a, output logic [15:0] d);
    @(posedge clk); #1;
    cfg_re = 1'b1; cfg_addr = a;
    @(negedge clk);
    d = cfg_rdata;
    @(posedge clk); #1;
    cfg_re = 1'b0;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 500 && !irq; i++) @(negedge clk);
  endtask

  initial begin
    logic [15:0] rd;
    int base;
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 7 + 3);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R11 reset state
    cfg_read(2'd3, rd);
    chk(rd == 16'h0 && !irq && !bus_req, "R11 reset status", rd, 0);

    // Device to memory, 4 words, immediate grant
    gnt_delay = 0;
    base = dev_seq;
    cfg_write(2'd0, 16'h0040);
    cfg_write(2'd1, 16'h0010);
    cfg_write(2'd2, 16'd4);
    cfg_read(2'd0, rd);
    chk(rd == 16'h0040, "R1 device address readback", rd, 16'h0040);
    cfg_write(2'd3, 16'b001);
    @(negedge clk);
    chk(bus_req == 1'b1, "R2 request after start", bus_req, 1);
    wait_irq();
    chk(irq == 1'b1, "R7 irq after block", irq, 1);
    for (int i = 0; i < 4; i++)
      chk(mem[16 + i] == 16'(32'hC000 + base + i), "R4 R3 device to memory word",
          mem[16 + i], 16'(32'hC000 + base + i));
    cfg_read(2'd2, rd);
    chk(rd == 16'd0, "R7 count at zero", rd, 0);
    cfg_read(2'd1, rd);
    chk(rd == 16'h0014, "R6 memory address stepped", rd, 16'h0014);
    cfg_read(2'd3, rd);
    chk(rd == 16'b10, "R11 status done bit", rd, 16'b10);
    @(negedge clk);
    chk(irq == 1'b0, "R8 status read clears irq", irq, 0);

    // Memory to device, 3 words, slow grant
    gnt_delay = 3;
    dev_log.delete();
    cfg_write(2'd0, 16'h0033);
    cfg_write(2'd1, 16'h0080);
    cfg_write(2'd2, 16'd3);
    cfg_write(2'd3, 16'b011);
    wait_irq();
    chk(dev_log.size() == 3, "R3 words written to device", dev_log.size(), 3);
    for (int i = 0; i < 3 && i < dev_log.size(); i++)
      chk(dev_log[i] == 16'((128 + i) * 7 + 3), "R4 memory to device word",
          dev_log[i], 16'((128 + i) * 7 + 3));
    cfg_write(2'd3, 16'b100);
    @(negedge clk);
    chk(irq == 1'b0, "R8 acknowledge clears irq", irq, 0);

    // Zero count start
    cfg_write(2'd2, 16'd0);
    cfg_write(2'd3, 16'b001);
    @(negedge clk);
    chk(irq == 1'b1 && !bus_req, "R9 zero count done without bus",
        {irq, bus_req}, 2'b10);
    cfg_write(2'd3, 16'b100);

    // Start and register writes while busy are ignored
    gnt_delay = 1;
    base = dev_seq;
    mem[8'h45] = 16'h0000;
    cfg_write(2'd0, 16'h0022);
    cfg_write(2'd1, 16'h0040);
    cfg_write(2'd2, 16'd5);
    cfg_write(2'd3, 16'b001);
    repeat (3) @(posedge clk);
    cfg_write(2'd2, 16'd9);
    cfg_write(2'd3, 16'b011);
    cfg_write(2'd0, 16'h0099);
    wait_irq();
    for (int i = 0; i < 5; i++)
      chk(mem[64 + i] == 16'(32'hC000 + base + i), "R10 block kept device to memory",
          mem[64 + i], 16'(32'hC000 + base + i));
    chk(mem[8'h45] == 16'h0, "R10 no extra word", mem[8'h45], 0);
    cfg_read(2'd0, rd);
    chk(rd == 16'h0022, "R1 device write ignored while busy", rd, 16'h0022);
    cfg_read(2'd1, rd);
    chk(rd == 16'h0045, "R6 final memory address", rd, 16'h0045);
    repeat (4) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule